// File: doc/BRIEF.md
# Nibble-pixel write-combining buffer

The block sits between a renderer that produces one 4-bit pixel per transfer and a 16-bit memory port. It holds the pixels aimed at one destination word in a pending register, so that a run of pixels landing side by side turns into one memory write rather than one read-modify-write per pixel. Source pixels may come from scattered texture locations. Only the destination word address decides which pixels are combined.

When the pending word is flushed, its coverage sets the kind of access. A fully covered word goes out as one plain write. A word whose covered nibbles fill whole byte lanes goes out as a byte-strobed write. Any other partial coverage costs a read followed by a merged write. An optional mode treats zero-valued pixels as transparent, so they never reach memory.

Top module: `pxpack_writer`

## Requirements
- R1: After reset no memory request is raised, `px_ready` is high and nothing is pending, so a flush pulse starts no access.
- R2: Pixel address p targets word p>>2 and nibble n = p[1:0]. Nibble n occupies bits [15-4n : 12-4n], so nibble 0 is bits [15:12].
- R3: When all four nibbles of the pending word are covered, exactly one write with `mem_be`=2'b11 is issued and no read.
- R4: A pending word covering exactly nibbles 0 and 1 is written once with `mem_be`=2'b10 (bit 1 enables [15:8]). One covering exactly nibbles 2 and 3 is written once with `mem_be`=2'b01 (bit 0 enables [7:0]). Neither case reads.
- R5: Any other partial coverage issues one read and then one write with `mem_be`=2'b11. The written word keeps the uncovered nibbles from memory.
- R6: A pixel aimed at a different word than the pending one is held off until the pending word has been written. It is then accepted into a fresh pending word.
- R7: A one-cycle `flush` pulse writes out the pending word. With nothing pending it starts no access.
- R8: With `px_skip_zero` high, a zero pixel is consumed but changes neither memory nor the pending word, and triggers no flush. With `px_skip_zero` low, a zero is written like any other value.
- R9: Two pixels for the same nibble of the pending word leave the later value in memory.
- R10: `mem_req` stays high with stable address, direction and data until `mem_ack`. Each access takes 3 cycles on a port that acks on the third cycle of the request, and `px_ready` is low whenever `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| px_valid | input | 1 | Pixel offered |
| px_ready | output | 1 | Pixel accepted this cycle when valid |
| px_addr | input | ADDR_W | Destination pixel address |
| px_value | input | 4 | Pixel value |
| px_skip_zero | input | 1 | Transparent mode: zero pixels are dropped |
| flush | input | 1 | Write out the pending word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Byte enables, bit 1 = [15:8], bit 0 = [7:0] |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes at this clock edge |

## Verification
The bench targets coverage patterns that sit on the boundary between the three access kinds. One byte lane filled exactly must not read, so a design that always falls back to read-modify-write shows up through an extra read. Two nibbles in different lanes must read and then merge, so a design that skipped the read would clobber the neighbouring nibbles. Mixing the wrong lane also corrupts neighbours, and the bench catches that by comparing memory against a nibble image. Transparent zeros between the pixels of a pending word would force a premature flush or overwrite a stored nibble if mishandled. An address change that was accepted before the flush would merge the pixel into the wrong word.

// File: rtl/pxpack_pkg.sv
package pxpack_pkg;
  localparam int PIX_W  = 4;
  localparam int WORD_W = 16;
  localparam int NIBS   = WORD_W / PIX_W;
  localparam int SEL_W  = $clog2(NIBS);
  localparam int LANES  = WORD_W / 8;
  localparam int NPL    = 8 / PIX_W;

  typedef enum logic [1:0] {FK_NONE, FK_FULL, FK_LANE, FK_RMW} flush_kind_e;

  // Bit mask of all word bits belonging to covered nibbles (nibble 0 = MSBs).
  function automatic logic [WORD_W-1:0] nib_bits(input logic [NIBS-1:0] m);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int i = 0; i < NIBS; i++)
      if (m[i]) r[WORD_W-1-PIX_W*i -: PIX_W] = '1;
    return r;
  endfunction

  // Keep memory bits outside the mask, take pending bits inside it.
  function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [NIBS-1:0]   m);
    logic [WORD_W-1:0] k;
    k = nib_bits(m);
    return (old_w & ~k) | (new_w & k);
  endfunction

  // Byte enables for lanes that are fully covered; bit LANES-1 is the top byte.
  function automatic logic [LANES-1:0] lane_be(input logic [NIBS-1:0] m);
    logic [LANES-1:0] b;
    b = '0;
    for (int l = 0; l < LANES; l++)
      b[LANES-1-l] = &m[l*NPL +: NPL];
    return b;
  endfunction

  function automatic flush_kind_e classify(input logic [NIBS-1:0] m);
    logic part;
    part = 1'b0;
    for (int l = 0; l < LANES; l++)
      if ((|m[l*NPL +: NPL]) && !(&m[l*NPL +: NPL])) part = 1'b1;
    if (m == '0)     return FK_NONE;
    else if (part)   return FK_RMW;
    else if (&m)     return FK_FULL;
    else             return FK_LANE;
  endfunction
endpackage

// File: rtl/pxpack_gather.sv
module pxpack_gather
  import pxpack_pkg::*;
#(
  parameter int WA_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [WA_W-1:0]   in_waddr,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic [PIX_W-1:0]  in_val,
  output logic [NIBS-1:0]   mask,
  output logic [WORD_W-1:0] data,
  output logic [WA_W-1:0]   waddr
);
  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    logic             v_q;
    logic [PIX_W-1:0] d_q;
    logic             hit;
    assign hit = load && (in_sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (clear) begin
        v_q <= 1'b0;
      end else if (hit) begin
        v_q <= 1'b1;
        d_q <= in_val;
      end
    end
    assign mask[g] = v_q;
    assign data[WORD_W-1-PIX_W*g -: PIX_W] = d_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) waddr <= '0;
    else if (load && mask == '0) waddr <= in_waddr;
  end
endmodule

// File: rtl/pxpack_port.sv
module pxpack_port
  import pxpack_pkg::*;
#(
  parameter int WA_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  flush_kind_e       kind,
  input  logic [LANES-1:0]  in_be,
  input  logic [WA_W-1:0]   in_waddr,
  input  logic [WORD_W-1:0] in_data,
  input  logic [NIBS-1:0]   in_mask,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  output logic              done,
  output logic              idle
);
  typedef enum logic [1:0] {P_IDLE, P_READ, P_WRITE} pst_e;
  pst_e              st;
  logic [WA_W-1:0]   addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= P_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      case (st)
        P_IDLE: if (start && kind != FK_NONE) begin
          addr_q  <= in_waddr;
          wdata_q <= in_data;
          be_q    <= (kind == FK_RMW) ? '1 : in_be;
          st      <= (kind == FK_RMW) ? P_READ : P_WRITE;
        end
        P_READ: if (mem_ack) begin
          wdata_q <= merge_word(mem_rdata, in_data, in_mask);
          st      <= P_WRITE;
        end
        P_WRITE: if (mem_ack) st <= P_IDLE;
        default: st <= P_IDLE;
      endcase
    end
  end

  assign mem_req   = (st != P_IDLE);
  assign mem_we    = (st == P_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_be    = be_q;
  assign done      = (st == P_WRITE) && mem_ack;
  assign idle      = (st == P_IDLE);
endmodule

// File: rtl/pxpack_writer.sv
module pxpack_writer
  import pxpack_pkg::*;
#(
  parameter  int ADDR_W = 12,
  localparam int WA_W   = ADDR_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              px_valid,
  output logic              px_ready,
  input  logic [ADDR_W-1:0] px_addr,
  input  logic [PIX_W-1:0]  px_value,
  input  logic              px_skip_zero,
  input  logic              flush,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  // Named internal events for the checker.
  logic [WA_W-1:0]   px_waddr;
  logic [SEL_W-1:0]  px_sel;
  logic              px_transparent;
  logic              px_take;
  logic              px_load;
  logic [NIBS-1:0]   pend_mask;
  logic [WORD_W-1:0] pend_data;
  logic [WA_W-1:0]   pend_waddr;
  logic              pend_any;
  logic              pend_full;
  logic              addr_clash;
  logic              flush_start;
  flush_kind_e       flush_kind;
  logic              write_done;
  logic              port_idle;

  assign px_waddr       = px_addr[ADDR_W-1:SEL_W];
  assign px_sel         = px_addr[SEL_W-1:0];
  assign px_transparent = px_skip_zero && (px_value == '0);
  assign pend_any       = |pend_mask;
  assign pend_full      = &pend_mask;
  assign addr_clash     = px_valid && !px_transparent && pend_any && (px_waddr != pend_waddr);
  assign flush_kind     = classify(pend_mask);
  assign flush_start    = port_idle && (pend_full || (flush && pend_any) || addr_clash);
  assign px_ready       = port_idle && !pend_full && !addr_clash && !(flush && pend_any);
  assign px_take        = px_valid && px_ready;
  assign px_load        = px_take && !px_transparent;

  pxpack_gather #(.WA_W(WA_W)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (px_load),
    .clear    (write_done),
    .in_waddr (px_waddr),
    .in_sel   (px_sel),
    .in_val   (px_value),
    .mask     (pend_mask),
    .data     (pend_data),
    .waddr    (pend_waddr)
  );

  pxpack_port #(.WA_W(WA_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (flush_start),
    .kind      (flush_kind),
    .in_be     (lane_be(pend_mask)),
    .in_waddr  (pend_waddr),
    .in_data   (pend_data),
    .in_mask   (pend_mask),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .done      (write_done),
    .idle      (port_idle)
  );
endmodule

// File: rtl/pxpack_writer_chk.sv
module pxpack_writer_chk
  import pxpack_pkg::*;
#(
  parameter int WA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              px_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [WA_W-1:0]   mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [LANES-1:0]  mem_be,
  input logic              mem_ack,
  input logic [NIBS-1:0]   pend_mask,
  input logic              flush_start,
  input flush_kind_e       flush_kind,
  input logic              write_done,
  input logic              px_take,
  input logic              px_transparent
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !px_ready); // R10
  AST_FULL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_start && (&pend_mask) |=> mem_req && mem_we && mem_be == 2'b11); // R3
  AST_LANE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    flush_start && flush_kind == FK_LANE |=> mem_req && mem_we &&
    mem_be == (($past(pend_mask) == 4'b0011) ? 2'b10 : 2'b01)); // R4
  AST_RMW_READS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_start && flush_kind == FK_RMW |=> mem_req && !mem_we); // R5
  AST_RMW_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ack |=> mem_req && mem_we && mem_be == 2'b11); // R5
  AST_CLEAR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    write_done |=> pend_mask == '0); // R6
  AST_CLEAR_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    px_take && px_transparent |=> $stable(pend_mask)); // R8
endmodule

bind pxpack_writer pxpack_writer_chk #(.WA_W(WA_W)) u_chk (.*);

// File: tb/pxpack_writer_test.sv
module pxpack_writer_test;
  localparam int CLK_NS = 10;
  localparam int ADDR_W = 8;
  localparam int NW     = 1 << (ADDR_W - 2);
  localparam int NPIX   = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic px_valid = 1'b0;
  logic px_ready;
  logic [ADDR_W-1:0] px_addr = '0;
  logic [3:0] px_value = '0;
  logic px_skip_zero = 1'b0;
  logic flush = 1'b0;
  logic mem_req, mem_we;
  logic [ADDR_W-3:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [1:0] mem_be;
  logic mem_ack;

  always #(CLK_NS/2) clk = ~clk;

  pxpack_writer #(.ADDR_W(ADDR_W)) uut (.*);

  // Memory model: acks on the third cycle of a request.
  logic [15:0] mem [NW];
  logic [3:0]  ref_nib [NPIX];
  int n_rd = 0, n_wr = 0, ack_cnt = 0;
  logic [1:0] last_be = '0;
  int last_waddr = 0;

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 16'h9E37) ^ 16'h5A5A;
  endfunction

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      ack_cnt <= 0;
      for (int i = 0; i < NW; i++) mem[i] <= init_word(i);
    end else if (mem_req) begin
      if (mem_ack) begin
        mem_ack <= 1'b0;
        ack_cnt <= 0;
        if (mem_we) begin
          if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
          if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
          n_wr <= n_wr + 1;
          last_be <= mem_be;
          last_waddr <= int'(mem_addr);
        end else begin
          n_rd <= n_rd + 1;
        end
      end else begin
        if (ack_cnt == 1) mem_ack <= 1'b1;
        ack_cnt <= ack_cnt + 1;
      end
    end
  end

  // Port monitor, sampled mid-cycle.
  int run = 0, lat_bad = 0, drop_bad = 0, busy_ready_bad = 0;
  logic req_d = 1'b0, ack_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (req_d && !ack_d && !mem_req) drop_bad++;
      if (mem_req && px_ready) busy_ready_bad++;
      if (mem_req) begin
        run++;
        if (mem_ack) begin
          if (run != 3) lat_bad++;
          run = 0;
        end
      end
    end
    req_d = mem_req;
    ack_d = mem_ack;
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] mem_nib(input int p);
    return mem[p >> 2][15 - 4*(p & 3) -: 4];
  endfunction

  task automatic cmp_mem(input string req);
    int mism = 0;
    for (int i = 0; i < NPIX; i++) if (mem_nib(i) != ref_nib[i]) mism++;
    chk(req, mism, 0);
  endtask

  task automatic put(input int a, input int v, input bit skip);
    @(negedge clk);
    px_valid = 1'b1;
    px_addr = ADDR_W'(a);
    px_value = 4'(v);
    px_skip_zero = skip;
    #1;
    while (!px_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    px_valid = 1'b0;
    if (!(skip && v == 0)) ref_nib[a] = 4'(v);
  endtask

  task automatic wait_quiet();
    repeat (3) @(negedge clk);
    while (mem_req) @(negedge clk);
  endtask

  task automatic drain();
    wait_quiet();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    wait_quiet();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int r0, w0, cur;
    void'($urandom(32'd1234));
    for (int i = 0; i < NPIX; i++)
      ref_nib[i] = init_word(i >> 2)[15 - 4*(i & 3) -: 4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req after reset", int'(mem_req), 0);
    chk("R1 ready after reset", int'(px_ready), 1);

    // R7 flush with nothing pending
    r0 = n_rd; w0 = n_wr;
    drain();
    chk("R7 empty flush accesses", (n_rd - r0) + (n_wr - w0), 0);

    // R3 full word, out-of-order nibbles
    r0 = n_rd; w0 = n_wr;
    put(6, 3, 0); put(4, 1, 0); put(7, 4, 0); put(5, 2, 0);
    wait_quiet();
    chk("R3 full word writes", n_wr - w0, 1);
    chk("R3 full word reads", n_rd - r0, 0);
    chk("R3 full word be", int'(last_be), 2'b11);
    cmp_mem("R2 full word image");

    // R4 upper byte lane
    r0 = n_rd; w0 = n_wr;
    put(12, 9, 0); put(13, 10, 0);
    drain();
    chk("R4 upper lane writes", n_wr - w0, 1);
    chk("R4 upper lane reads", n_rd - r0, 0);
    chk("R4 upper lane be", int'(last_be), 2'b10);
    // R4 lower byte lane
    r0 = n_rd; w0 = n_wr;
    put(19, 11, 0); put(18, 12, 0);
    drain();
    chk("R4 lower lane reads", n_rd - r0, 0);
    chk("R4 lower lane be", int'(last_be), 2'b01);
    cmp_mem("R4 lane image");

    // R5 odd coverage: nibbles 0 and 2
    r0 = n_rd; w0 = n_wr;
    put(32, 13, 0); put(34, 14, 0);
    drain();
    chk("R5 rmw reads", n_rd - r0, 1);
    chk("R5 rmw writes", n_wr - w0, 1);
    chk("R5 rmw be", int'(last_be), 2'b11);
    cmp_mem("R5 rmw image");

    // R6 address change forces flush before accept
    w0 = n_wr;
    put(21, 5, 0);
    put(26, 6, 0);
    chk("R6 flush before new word", n_wr - w0, 1);
    chk("R6 flushed word addr", last_waddr, 5);
    drain();
    cmp_mem("R6 image");

    // R8 transparent zero does not disturb pending word
    w0 = n_wr;
    put(28, 5, 0);
    put(36, 0, 1);
    repeat (4) @(negedge clk);
    chk("R8 no flush on transparent", n_wr - w0, 0);
    r0 = n_rd;
    put(29, 3, 0);
    drain();
    chk("R8 single lane write", n_wr - w0, 1);
    chk("R8 no read", n_rd - r0, 0);
    put(44, 6, 0); drain();
    r0 = n_rd; w0 = n_wr;
    put(44, 0, 1);
    drain();
    chk("R8 transparent accesses", (n_rd - r0) + (n_wr - w0), 0);
    put(43, 7, 0); drain();
    put(43, 0, 0); drain();
    chk("R8 opaque zero stored", int'(mem_nib(43)), 0);
    cmp_mem("R8 image");

    // R9 same nibble twice
    put(46, 4, 0); put(46, 9, 0);
    drain();
    chk("R9 last value wins", int'(mem_nib(46)), 9);

    // Random rows in both modes
    for (int rnd = 0; rnd < 4; rnd++) begin
      cur = int'($urandom_range(0, NPIX - 1));
      for (int k = 0; k < 150; k++) begin
        int v;
        bit sk;
        if ($urandom_range(0, 5) == 0) cur = int'($urandom_range(0, NPIX - 1));
        else cur = (cur + 1) % NPIX;
        v = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 15));
        sk = (rnd >= 2) ? 1'b1 : bit'($urandom_range(0, 1));
        put(cur, v, sk);
      end
      drain();
      cmp_mem("R2 R8 random image");
    end

    chk("R10 request latency", lat_bad, 0);
    chk("R10 request dropped before ack", drop_bad, 0);
    chk("R10 ready while busy", busy_ready_bad, 0);
    finish_run();
  end
endmodule